// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

This peripheral holds three independent up-counters, each watched by three match comparators. Software reaches it through a simple synchronous register bus with write strobe, read strobe, word address and data. One global run register starts and stops the counters, one bit per timer. Each timer has its own mode, status, interrupt-enable, count and match registers. The counters advance only on cycles where the count-enable tick input is high, so the tick sets the time base.

Each comparator raises a sticky status bit when its timer's count equals its match value on a tick. The status bit is cleared by writing a 1 to it. A timer in periodic mode returns to zero when comparator 0 matches, which makes a programmable period. A timer in free-running mode keeps counting and wraps through its whole range. All enabled status bits of all timers are combined into a single interrupt line.

The address is a word address. Bits [7:4] select a block: 0 is the global block, and t+1 is timer t. Bits [3:0] select the register within that block.

Top module: `mtimer_top`

## Requirements
- R1: After reset the following all read 0: the run register, every mode, status and interrupt-enable register, and every count. Every match register reads all ones, and `irq` is low.
- R2: The run register is at address 0x00. Bit t runs timer t: bit 0 is timer 0, bit 1 is timer 1 and bit 2 is timer 2. A timer whose bit is 0 does not count on ticks.
- R3: Writing a run bit from 0 to 1 restarts that counter at zero, and a tick in the same cycle is ignored. Writing 1 to a bit that is already 1 does not disturb the count. Clearing the bit freezes the count at its current value.
- R4: Match register j of timer t is at 0x(t+1)4+j. On a tick where a running timer's count equals match j, status bit j sets. So a match value of N-1 sets the status on the Nth tick after the timer is enabled.
- R5: The mode register of timer t is at 0x(t+1)0, bit 0. A value of 1 selects periodic mode: on a tick where comparator 0 matches, the count becomes 0 instead of the match value plus one.
- R6: A mode value of 0 selects free-running mode. A match sets status and the count still increments. The count wraps from all ones to zero.
- R7: The status register of timer t is at 0x(t+1)1, with bit j for comparator j. A match sets its bit whether or not its interrupt is enabled. Writing 1 to a bit clears it, and bits written as 0 are kept.
- R8: If a status-clear write and a new match of the same bit fall in the same cycle, the bit stays set.
- R9: The interrupt-enable register of timer t is at 0x(t+1)2, with bit j for comparator j. `irq` is high exactly when some timer has a status bit set whose enable bit is also set. Writing 0 masks all of that timer's matches.
- R10: The count of timer t can be read at 0x(t+1)3, and writes to it are ignored. Read data for the address presented with `rdEn` appears on `rdData` in the following cycle. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| tick | input | 1 | Count-enable tick |
| rdData | output | DATA_W | Registered read data |
| irq | output | 1 | Combined match interrupt |

## Verification
A corrupted counter shows up as a wrong value on the next read of a count register. It also shows up as a status bit that sets one or more ticks early or late. A periodic timer with a bad reload drifts further off with every period, so a few periods make the error plain. A lost or stuck status bit is seen on `irq` in the same cycle whenever that bit's enable is set, and on any status read otherwise. A wrong run or restart decision is visible on the very next count read.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int NUM_TMR = 3;
  localparam int NUM_CMP = 3;

  // strobes and static controls from the register block to the counters
  typedef struct packed {
    logic [NUM_TMR-1:0]              run;
    logic [NUM_TMR-1:0]              restart;
    logic [NUM_TMR-1:0]              periodic;
    logic [NUM_TMR-1:0][NUM_CMP-1:0] clrMask;
  } tmrStrobe_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         wrEn,
  input  logic                                         rdEn,
  input  logic [ADDR_W-1:0]                            addr,
  input  logic [DATA_W-1:0]                            wrData,
  input  logic [NUM_TMR-1:0][NUM_CMP-1:0]              statusIn,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]                countIn,
  output tmrStrobe_t                                   strb,
  output logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]   matchOut,
  output logic [DATA_W-1:0]                            rdData,
  output logic                                         irq
);
  localparam int OFF_W      = 4;
  localparam int BLK_W      = ADDR_W - OFF_W;
  localparam int OFF_MODE   = 0;
  localparam int OFF_STAT   = 1;
  localparam int OFF_IE     = 2;
  localparam int OFF_COUNT  = 3;
  localparam int OFF_MATCH0 = 4;

  logic [BLK_W-1:0] blk;
  logic [OFF_W-1:0] off;
  logic             globalSel;
  logic [NUM_TMR-1:0] tmrSel;
  logic [NUM_TMR-1:0] enReg;
  logic [NUM_TMR-1:0] modeReg;
  logic [NUM_TMR-1:0][NUM_CMP-1:0] ieReg;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] matchReg;
  logic [DATA_W-1:0] rdNext;

  assign blk       = addr[ADDR_W-1:OFF_W];
  assign off       = addr[OFF_W-1:0];
  assign globalSel = (blk == '0) && (off == '0);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_sel
    assign tmrSel[t] = (blk == BLK_W'(t + 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      modeReg  <= '0;
      ieReg    <= '0;
      matchReg <= '1;
    end else if (wrEn) begin
      if (globalSel) enReg <= wrData[NUM_TMR-1:0];
      for (int t = 0; t < NUM_TMR; t++) begin
        if (tmrSel[t]) begin
          if (off == OFF_W'(OFF_MODE)) modeReg[t] <= wrData[0];
          if (off == OFF_W'(OFF_IE))   ieReg[t]   <= wrData[NUM_CMP-1:0];
          for (int j = 0; j < NUM_CMP; j++) begin
            if (off == OFF_W'(OFF_MATCH0 + j)) matchReg[t][j] <= wrData[CNT_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    strb.run      = enReg;
    strb.periodic = modeReg;
    strb.restart  = (wrEn && globalSel) ? (wrData[NUM_TMR-1:0] & ~enReg) : '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      strb.clrMask[t] = (wrEn && tmrSel[t] && off == OFF_W'(OFF_STAT))
                        ? wrData[NUM_CMP-1:0] : '0;
    end
  end

  assign matchOut = matchReg;
  assign irq      = |(statusIn & ieReg);

  always_comb begin
    rdNext = '0;
    if (globalSel) rdNext[NUM_TMR-1:0] = enReg;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (tmrSel[t]) begin
        if (off == OFF_W'(OFF_MODE))  rdNext[0] = modeReg[t];
        if (off == OFF_W'(OFF_STAT))  rdNext[NUM_CMP-1:0] = statusIn[t];
        if (off == OFF_W'(OFF_IE))    rdNext[NUM_CMP-1:0] = ieReg[t];
        if (off == OFF_W'(OFF_COUNT)) rdNext = DATA_W'(countIn[t]);
        for (int j = 0; j < NUM_CMP; j++) begin
          if (off == OFF_W'(OFF_MATCH0 + j)) rdNext = DATA_W'(matchReg[t][j]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         tick,
  input  tmrStrobe_t                                   strb,
  input  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]   matchIn,
  output logic [NUM_TMR-1:0][NUM_CMP-1:0]              statusOut,
  output logic [NUM_TMR-1:0][CNT_W-1:0]                countOut
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic [CNT_W-1:0]   cnt;
    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] stat;
    logic               step;

    assign step = strb.run[t] && tick && !strb.restart[t];

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
      assign hit[j] = step && (cnt == matchIn[t][j]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cnt <= '0;
      else if (strb.restart[t]) cnt <= '0;
      else if (step)            cnt <= (strb.periodic[t] && hit[0]) ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stat <= '0;
      else       stat <= hit | (stat & ~strb.clrMask[t]);
    end

    assign statusOut[t] = stat;
    assign countOut[t]  = cnt;
  end
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrStrobe_t strb;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] matchVals;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]            statusBits;
  logic [NUM_TMR-1:0][CNT_W-1:0]              countBits;
  logic [NUM_TMR-1:0]                         runBits;

  assign runBits = strb.run;

  mtimer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .statusIn(statusBits), .countIn(countBits),
    .strb(strb), .matchOut(matchVals), .rdData(rdData), .irq(irq)
  );

  mtimer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .matchIn(matchVals), .statusOut(statusBits), .countOut(countBits)
  );
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic                            tick,
  input logic                            irq,
  input logic [NUM_TMR-1:0][NUM_CMP-1:0] statusBits,
  input logic [NUM_TMR-1:0][CNT_W-1:0]   countBits,
  input logic [NUM_TMR-1:0]              runBits
);
  AST_STATUS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((statusBits & ~$past(statusBits)) != '0) |-> $past(tick)); // R4

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusBits) & ~statusBits) != '0) |-> $past(wrEn)); // R7

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusBits != '0)); // R9

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
      !runBits[t] |=> (countBits[t] == $past(countBits[t]) || countBits[t] == '0)); // R3

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      (runBits[t] && tick) |=>
        (countBits[t] == CNT_W'($past(countBits[t]) + 1'b1) || countBits[t] == '0)); // R6
  end
endmodule

bind mtimer_top mtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .tick(tick), .irq(irq),
  .statusBits(statusBits), .countBits(countBits), .runBits(runBits)
);

// File: tb/mtimer_top_tb.sv
`timescale 1ns/1ps
module mtimer_top_tb;
  localparam int W  = 8;
  localparam int NT = 3;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model
  logic [W-1:0]  mCnt [NT];
  logic [NT-1:0] mEn;
  logic [NT-1:0] mMode;
  logic [NC-1:0] mIe [NT];
  logic [NC-1:0] mSt [NT];
  logic [W-1:0]  mMt [NT][NC];

  mtimer_top #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .tick(tick), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] ta(int t, int off);
    return 8'((t + 1) * 16 + off);
  endfunction

  task automatic modelReset();
    mEn = '0; mMode = '0;
    for (int t = 0; t < NT; t++) begin
      mCnt[t] = '0; mIe[t] = '0; mSt[t] = '0;
      for (int j = 0; j < NC; j++) mMt[t][j] = '1;
    end
  endtask

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    int blk = a[7:4];
    int off = a[3:0];
    if (blk == 0 && off == 0) begin
      for (int t = 0; t < NT; t++) if (d[t] && !mEn[t]) mCnt[t] = '0;
      mEn = d[NT-1:0];
    end else if (blk >= 1 && blk <= NT) begin
      int t = blk - 1;
      if (off == 0) mMode[t] = d[0];
      if (off == 1) mSt[t] = mSt[t] & ~d[NC-1:0];
      if (off == 2) mIe[t] = d[NC-1:0];
      if (off >= 4 && off < 4 + NC) mMt[t][off-4] = d[W-1:0];
    end
  endtask

  task automatic modelTick();
    for (int t = 0; t < NT; t++) begin
      if (mEn[t]) begin
        logic [NC-1:0] m;
        for (int j = 0; j < NC; j++) m[j] = (mCnt[t] == mMt[t][j]);
        mSt[t] = mSt[t] | m;
        mCnt[t] = (mMode[t] && m[0]) ? '0 : mCnt[t] + 1'b1;
      end
    end
  endtask

  function automatic logic [31:0] expRead(logic [7:0] a);
    int blk = a[7:4];
    int off = a[3:0];
    logic [31:0] v = '0;
    if (blk == 0 && off == 0) v[NT-1:0] = mEn;
    else if (blk >= 1 && blk <= NT) begin
      int t = blk - 1;
      if (off == 0) v[0] = mMode[t];
      if (off == 1) v[NC-1:0] = mSt[t];
      if (off == 2) v[NC-1:0] = mIe[t];
      if (off == 3) v[W-1:0] = mCnt[t];
      if (off >= 4 && off < 4 + NC) v[W-1:0] = mMt[t][off-4];
    end
    return v;
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int t = 0; t < NT; t++) r |= |(mSt[t] & mIe[t]);
    return r;
  endfunction

  task automatic chkEq(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doWriteTick(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; tick = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    modelWrite(a, d);
    modelTick();
  endtask

  task automatic doTicks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      modelTick();
    end
  endtask

  task automatic doRead(logic [7:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic chkReg(string tag, logic [7:0] a);
    logic [31:0] v;
    doRead(a, v);
    chkEq(tag, v, expRead(a));
  endtask

  task automatic chkLit(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    doRead(a, v);
    chkEq(tag, v, exp);
  endtask

  task automatic chkIrq(string tag);
    chkEq(tag, {31'b0, irq}, {31'b0, expIrq()});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    chkLit("R1 run reg", 8'h00, 32'h0);
    for (int t = 0; t < NT; t++) begin
      chkLit("R1 mode", ta(t, 0), 32'h0);
      chkLit("R1 status", ta(t, 1), 32'h0);
      chkLit("R1 irq enable", ta(t, 2), 32'h0);
      chkLit("R1 count", ta(t, 3), 32'h0);
      for (int j = 0; j < NC; j++) chkLit("R1 match", ta(t, 4 + j), 32'hFF);
    end
    chkEq("R1 irq", {31'b0, irq}, 32'h0);

    // R4 match N-1 fires on Nth tick (N=5)
    doWrite(ta(0, 4), 32'd4);
    doWrite(8'h00, 32'h1);
    doTicks(4);
    chkLit("R4 no early match", ta(0, 1), 32'h0);
    doTicks(1);
    chkLit("R4 match on fifth tick", ta(0, 1), 32'h1);
    chkLit("R6 free count continues", ta(0, 3), 32'd5);
    chkEq("R7 status without enable, irq", {31'b0, irq}, 32'h0);

    // R2 only the selected timer runs
    chkLit("R2 timer1 idle", ta(1, 3), 32'h0);
    doWrite(8'h00, 32'h2);
    doTicks(3);
    chkLit("R2 timer0 frozen", ta(0, 3), 32'd5);
    chkLit("R2 timer1 counts", ta(1, 3), 32'd3);

    // R3 rewrite of a set bit keeps the count, 0->1 restarts
    doWrite(8'h00, 32'h2);
    chkLit("R3 no restart on rewrite", ta(1, 3), 32'd3);
    doWrite(8'h00, 32'h3);
    chkLit("R3 restart timer0", ta(0, 3), 32'd0);
    chkLit("R3 timer1 untouched", ta(1, 3), 32'd3);
    doWriteTick(8'h00, 32'h0);
    doWriteTick(8'h00, 32'h1);
    chkLit("R3 tick ignored on restart", ta(0, 3), 32'd0);

    // R5 periodic reload
    doWrite(ta(1, 0), 32'h1);
    doWrite(ta(1, 4), 32'd2);
    doWrite(8'h00, 32'h0);
    doWrite(8'h00, 32'h2);
    doTicks(3);
    chkLit("R5 reload to zero", ta(1, 3), 32'd0);
    chkLit("R5 status bit0", ta(1, 1), 32'h1);
    doTicks(5);
    chkLit("R5 second period", ta(1, 3), 32'd2);

    // R7 write-one-to-clear, zero bits kept
    doWrite(ta(1, 5), 32'd0);
    doWrite(8'h00, 32'h0);
    doWrite(8'h00, 32'h2);
    doTicks(1);
    chkLit("R7 two bits set", ta(1, 1), 32'h3);
    doWrite(ta(1, 1), 32'h1);
    chkLit("R7 clear only bit0", ta(1, 1), 32'h2);

    // R9 masking
    doWrite(ta(1, 2), 32'h1);
    chkEq("R9 masked bit", {31'b0, irq}, 32'h0);
    doWrite(ta(1, 2), 32'h2);
    chkEq("R9 enabled bit", {31'b0, irq}, 32'h1);
    doWrite(ta(1, 2), 32'h0);
    chkEq("R9 all masked", {31'b0, irq}, 32'h0);

    // R10 count is read-only
    doWrite(ta(1, 3), 32'hAB);
    chkReg("R10 count write ignored", ta(1, 3));

    // R6 wrap through full range on timer2 (matches all ones)
    doWrite(8'h00, 32'h4);
    doTicks(256);
    chkLit("R6 wrapped to zero", ta(2, 3), 32'd0);
    chkLit("R6 all-ones match", ta(2, 1), 32'h7);

    // R8 clear and match in the same cycle
    doWrite(ta(0, 0), 32'h0);
    doWrite(ta(0, 5), 32'd1);
    doWrite(ta(0, 1), 32'h7);
    doWrite(8'h00, 32'h0);
    doWrite(8'h00, 32'h1);
    doTicks(1);
    doWriteTick(ta(0, 1), 32'h2);
    chkLit("R8 match wins over clear", ta(0, 1), 32'h2);

    // random mix, checked against the model
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      int t  = $urandom_range(0, NT - 1);
      if (op <= 3) begin
        int sel = $urandom_range(0, 6);
        logic [7:0] a;
        logic [31:0] d = $urandom;
        case (sel)
          0: a = 8'h00;
          1: a = ta(t, 0);
          2: a = ta(t, 1);
          3: a = ta(t, 2);
          default: begin
            a = ta(t, sel);
            if (d[3]) d = $urandom_range(0, 12);
          end
        endcase
        if (sel == 6) a = ta(t, 3);
        doWrite(a, d);
      end else if (op <= 6) begin
        doTicks($urandom_range(1, 12));
      end else begin
        int off = $urandom_range(0, 6);
        chkReg("R10 random read", (op == 9) ? 8'h00 : ta(t, off));
      end
      chkIrq("R9 random irq");
    end

    finishRun();
  end
endmodule